// File: doc/BRIEF.md
# Accumulator ALU with Skip Conditions

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each cycle it takes the accumulator, an operand byte, the current carry and half-carry, and either a 3-bit two-operand code or a 4-bit single-operand code. One clock later it presents the new accumulator value, the new carry and half-carry, a flag-write enable and a skip request. The machine has no zero, sign or overflow flags. Conditional control flow relies on skip requests instead: the sequencer discards the next instruction when `skip_req` is high.

Only add-with-carry and subtract-with-carry, the two rotates through carry, and the explicit set-carry and clear-carry operations write flags. Every other operation raises no write enable and returns the incoming carry and half-carry unchanged on the flag outputs. Subtraction is the sum of the accumulator, the inverted operand and the carry, so a carry of 1 means that no borrow occurred. For BCD work, software adds a bias of 0x66 to one operand, adds the other operand with carry, and then applies decimal correct, which removes 0x60 and/or 0x06 where no carry came out of that digit.

Operand fetch, register writeback and instruction sequencing belong to other blocks.

Top module: `acc_alu_core`

## Requirements
- R1: During a clock edge with `rst_n` low, every output is cleared to zero. While reset is held, the registered outputs read zero.
- R2: Two-operand code 000 (add with carry) registers `{carry_out,res_out} = A + B + carry_in`. `hcarry_out` is the carry out of bit 3 of that sum, and `flag_we` is 1. All results appear on the clock edge that follows the inputs.
- R3: Code 001 (subtract with carry) registers `{carry_out,res_out} = A + ~B + carry_in`, with `hcarry_out` the carry out of bit 3 and `flag_we` set to 1.
- R4: Code 100 (plain add) registers `res_out = A + B` with the incoming carry ignored. `flag_we` is 0, and the flag outputs equal `carry_in`/`hcarry_in`.
- R5: Codes 101 (AND), 110 (XOR) and 111 (OR) register the bitwise result. They raise no skip and write no flags.
- R6: Code 010 (equality compare) sets `skip_req` when A differs from B. `res_out` equals A, and no flag is written.
- R7: Code 011 (greater-than compare) sets `skip_req` when A is less than or equal to B, compared unsigned. `res_out` equals A, and no flag is written.
- R8: Single-operand codes 1 (clear), 2 (increment) and 3 (decrement) give 0, A+1 and A-1 respectively. The carry is left unchanged, and `flag_we` is 0.
- R9: Single-operand code 4 exchanges the two nibbles of A.
- R10: Code 6 rotates left through carry (`{carry_out,res_out} = {A,carry_in}`). Code 7 rotates right through carry (`res_out = {carry_in,A[7:1]}`, `carry_out = A[0]`). Both write flags and keep the half-carry.
- R11: Code 5 (decimal correct) gives A minus 0x60 when `carry_in` is 0 and minus 0x06 when `hcarry_in` is 0, both modulo 256, and it writes no flags.
- R12: Code 8 sets the carry and code 9 clears it, each with `flag_we` 1 and A passed through. Code 10 skips when carry is clear, and code 11 skips when carry is set.
- R13: Code 12 (test under mask) skips when `(A & B) == 0` and passes A through.
- R14: Whenever `flag_we` is 0 after a reset-free cycle, `carry_out`/`hcarry_out` equal the previous cycle's `carry_in`/`hcarry_in`. Codes 0 and 13 to 15 pass A through with no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_unary | input | 1 | 1 selects the single-operand code, 0 the two-operand code |
| bin_op | input | 3 | Two-operand operation code |
| un_op | input | 4 | Single-operand operation code |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Operand byte (also the mask for test under mask) |
| carry_in | input | 1 | Current carry flag |
| hcarry_in | input | 1 | Current half-carry flag |
| res_out | output | 8 | Registered result |
| carry_out | output | 1 | Registered carry value |
| hcarry_out | output | 1 | Registered half-carry value |
| flag_we | output | 1 | 1 when the flags are to be written |
| skip_req | output | 1 | 1 when the next instruction is to be skipped |

## Verification
The properties assume that every input holds a known value at each rising edge, because each check compares a registered output with the previous cycle's inputs through a single-cycle look-back. They also require that look-back to reach a cycle in which reset was released. The bench keeps to these assumptions: it sets every input at time zero and changes inputs only on falling edges. It also guards each property with the previous reset state, so the first cycle after reset compares against the cleared outputs rather than against a computed result.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
// Package: operation codes shared by the accumulator ALU and its checker.
// Assumes the two-operand code is 3 bits and the single-operand code 4 bits.
package acc_alu_pkg;

    typedef enum logic [2:0] {
        BOP_ADC  = 3'd0,
        BOP_SUBC = 3'd1,
        BOP_CEQ  = 3'd2,
        BOP_CGT  = 3'd3,
        BOP_ADD  = 3'd4,
        BOP_AND  = 3'd5,
        BOP_XOR  = 3'd6,
        BOP_OR   = 3'd7
    } bin_op_e;

    typedef enum logic [3:0] {
        UOP_NOP  = 4'd0,
        UOP_CLR  = 4'd1,
        UOP_INC  = 4'd2,
        UOP_DEC  = 4'd3,
        UOP_SWAP = 4'd4,
        UOP_DCOR = 4'd5,
        UOP_RLC  = 4'd6,
        UOP_RRC  = 4'd7,
        UOP_SC   = 4'd8,
        UOP_RC   = 4'd9,
        UOP_SKCC = 4'd10,
        UOP_SKCS = 4'd11,
        UOP_TSTM = 4'd12
    } un_op_e;

endpackage

// File: rtl/acc_alu_adder.sv
`timescale 1ns/1ps
// Module: split adder giving the sum, the carry out of the top bit and the
// carry out of the lower half (half-carry).
// Assumes DATA_W is even; the half-carry boundary is DATA_W/2.
module acc_alu_adder #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              hcout_o
);
    localparam int HALF  = DATA_W / 2;
    localparam int UPPER = DATA_W - HALF;

    logic [HALF:0]  lo_sum;
    logic [UPPER:0] hi_sum;

    // Add the lower half first so its carry feeds the upper half.
    always_comb begin
        lo_sum  = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]}
                + {{HALF{1'b0}}, cin_i};
        hi_sum  = {1'b0, a_i[DATA_W-1:HALF]} + {1'b0, b_i[DATA_W-1:HALF]}
                + {{UPPER{1'b0}}, lo_sum[HALF]};
        sum_o   = {hi_sum[UPPER-1:0], lo_sum[HALF-1:0]};
        cout_o  = hi_sum[UPPER];
        hcout_o = lo_sum[HALF];
    end

endmodule

// File: rtl/acc_alu_binary.sv
`timescale 1ns/1ps
// Module: two-operand operations (add/subtract with carry, plain add,
// logic and the two compare-and-skip forms).
// Assumes unsigned compares; the flag outputs pass the inputs through
// unless the operation is one of the two carry-chained arithmetic codes.
module acc_alu_binary
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_i,
    input  logic              hc_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o,
    output logic              hc_o,
    output logic              we_o,
    output logic              skip_o
);
    logic [DATA_W-1:0] add_b;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum;
    logic              add_cout;
    logic              add_hcout;

    // Pick the adder's operand and carry-in: invert for subtract, no carry for plain add.
    always_comb begin
        add_b   = (bin_op_e'(op_i) == BOP_SUBC) ? ~b_i : b_i;
        add_cin = (bin_op_e'(op_i) == BOP_ADD) ? 1'b0 : c_i;
    end

    acc_alu_adder #(.DATA_W(DATA_W)) u_add (
        .a_i    (a_i),
        .b_i    (add_b),
        .cin_i  (add_cin),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .hcout_o(add_hcout)
    );

    // Select the result, the flag values and the skip request per code.
    always_comb begin
        res_o  = a_i;
        c_o    = c_i;
        hc_o   = hc_i;
        we_o   = 1'b0;
        skip_o = 1'b0;
        case (bin_op_e'(op_i))
            BOP_ADC, BOP_SUBC: begin
                res_o = add_sum;
                c_o   = add_cout;
                hc_o  = add_hcout;
                we_o  = 1'b1;
            end
            BOP_ADD: res_o  = add_sum;
            BOP_CEQ: skip_o = (a_i != b_i);
            BOP_CGT: skip_o = !(a_i > b_i);
            BOP_AND: res_o  = a_i & b_i;
            BOP_XOR: res_o  = a_i ^ b_i;
            BOP_OR:  res_o  = a_i | b_i;
            default: res_o  = a_i;
        endcase
    end

endmodule

// File: rtl/acc_alu_unary.sv
`timescale 1ns/1ps
// Module: single-operand accumulator operations, carry control, carry
// tests and test under mask.
// Assumes the operand byte is used only as the mask of the mask test;
// unlisted codes pass the accumulator through untouched.
module acc_alu_unary
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_i,
    input  logic              hc_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o,
    output logic              hc_o,
    output logic              we_o,
    output logic              skip_o
);
    localparam int HALF = DATA_W / 2;
    localparam logic [DATA_W-1:0] LO_ADJ = DATA_W'(6);
    localparam logic [DATA_W-1:0] HI_ADJ = LO_ADJ << HALF;

    logic [DATA_W-1:0] dcor_val;

    // Decimal correct: take 6 off each digit that produced no carry.
    always_comb begin
        dcor_val = a_i - (c_i ? '0 : HI_ADJ) - (hc_i ? '0 : LO_ADJ);
    end

    // Select the result, the flag values and the skip request per code.
    always_comb begin
        res_o  = a_i;
        c_o    = c_i;
        hc_o   = hc_i;
        we_o   = 1'b0;
        skip_o = 1'b0;
        case (un_op_e'(op_i))
            UOP_CLR:  res_o = '0;
            UOP_INC:  res_o = a_i + DATA_W'(1);
            UOP_DEC:  res_o = a_i - DATA_W'(1);
            UOP_SWAP: res_o = {a_i[HALF-1:0], a_i[DATA_W-1:HALF]};
            UOP_DCOR: res_o = dcor_val;
            UOP_RLC: begin
                res_o = {a_i[DATA_W-2:0], c_i};
                c_o   = a_i[DATA_W-1];
                we_o  = 1'b1;
            end
            UOP_RRC: begin
                res_o = {c_i, a_i[DATA_W-1:1]};
                c_o   = a_i[0];
                we_o  = 1'b1;
            end
            UOP_SC: begin
                c_o  = 1'b1;
                we_o = 1'b1;
            end
            UOP_RC: begin
                c_o  = 1'b0;
                we_o = 1'b1;
            end
            UOP_SKCC: skip_o = !c_i;
            UOP_SKCS: skip_o = c_i;
            UOP_TSTM: skip_o = ((a_i & b_i) == '0);
            default:  res_o  = a_i;
        endcase
    end

endmodule

// File: rtl/acc_alu_core.sv
`timescale 1ns/1ps
// Module: top of the accumulator ALU. Chooses between the two-operand and
// single-operand paths and registers the outcome for one cycle.
// Assumes a new operation may be presented every cycle; the synchronous
// active-low reset clears all registered outputs.
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_unary,
    input  logic [2:0]        bin_op,
    input  logic [3:0]        un_op,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              carry_in,
    input  logic              hcarry_in,
    output logic [DATA_W-1:0] res_out,
    output logic              carry_out,
    output logic              hcarry_out,
    output logic              flag_we,
    output logic              skip_req
);
    logic [DATA_W-1:0] b_res, u_res, n_res;
    logic              b_c, b_hc, b_we, b_skip;
    logic              u_c, u_hc, u_we, u_skip;
    logic              n_c, n_hc, n_we, n_skip;

    acc_alu_binary #(.DATA_W(DATA_W)) u_bin (
        .op_i  (bin_op),
        .a_i   (acc_in),
        .b_i   (opnd_in),
        .c_i   (carry_in),
        .hc_i  (hcarry_in),
        .res_o (b_res),
        .c_o   (b_c),
        .hc_o  (b_hc),
        .we_o  (b_we),
        .skip_o(b_skip)
    );

    acc_alu_unary #(.DATA_W(DATA_W)) u_una (
        .op_i  (un_op),
        .a_i   (acc_in),
        .b_i   (opnd_in),
        .c_i   (carry_in),
        .hc_i  (hcarry_in),
        .res_o (u_res),
        .c_o   (u_c),
        .hc_o  (u_hc),
        .we_o  (u_we),
        .skip_o(u_skip)
    );

    // Route the selected path's results toward the output register.
    always_comb begin
        if (is_unary) begin
            n_res = u_res; n_c = u_c; n_hc = u_hc; n_we = u_we; n_skip = u_skip;
        end else begin
            n_res = b_res; n_c = b_c; n_hc = b_hc; n_we = b_we; n_skip = b_skip;
        end
    end

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out    <= '0;
            carry_out  <= 1'b0;
            hcarry_out <= 1'b0;
            flag_we    <= 1'b0;
            skip_req   <= 1'b0;
        end else begin
            res_out    <= n_res;
            carry_out  <= n_c;
            hcarry_out <= n_hc;
            flag_we    <= n_we;
            skip_req   <= n_skip;
        end
    end

endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
// Module: property checker for acc_alu_core, attached by bind below.
// Assumes inputs are known at every rising edge.
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              is_unary,
    input logic [2:0]        bin_op,
    input logic [3:0]        un_op,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic              carry_in,
    input logic              hcarry_in,
    input logic [DATA_W-1:0] res_out,
    input logic              carry_out,
    input logic              hcarry_out,
    input logic              flag_we,
    input logic              skip_req
);
    localparam int HALF = DATA_W / 2;

    // R1: a reset cycle leaves every output cleared
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (res_out == '0 && !carry_out && !hcarry_out && !flag_we && !skip_req));

    // R4: plain add writes no flag and keeps the carry
    a_r4_add_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!is_unary) && $past(bin_op) == BOP_ADD)
        |-> (!flag_we && carry_out == $past(carry_in)));

    // R5: logic codes never skip and never write flags
    a_r5_logic_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!is_unary) && $past(bin_op) >= BOP_AND)
        |-> (!skip_req && !flag_we));

    // R6: equality compare skips exactly on mismatch
    a_r6_eq_skip: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!is_unary) && $past(bin_op) == BOP_CEQ)
        |-> (skip_req == ($past(acc_in) != $past(opnd_in)) && res_out == $past(acc_in)));

    // R7: greater-than compare skips when A <= B
    a_r7_gt_skip: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!is_unary) && $past(bin_op) == BOP_CGT)
        |-> (skip_req == ($past(acc_in) <= $past(opnd_in))));

    // R9: nibble swap
    a_r9_swap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(is_unary) && $past(un_op) == UOP_SWAP)
        |-> (res_out[HALF-1:0] == $past(acc_in[DATA_W-1:HALF])
             && res_out[DATA_W-1:HALF] == $past(acc_in[HALF-1:0])));

    // R10: rotate left moves the top bit into carry
    a_r10_rlc_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(is_unary) && $past(un_op) == UOP_RLC)
        |-> (flag_we && carry_out == $past(acc_in[DATA_W-1]) && res_out[0] == $past(carry_in)));

    // R14: without a flag write the flags pass through
    a_r14_flag_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !flag_we)
        |-> (carry_out == $past(carry_in) && hcarry_out == $past(hcarry_in)));

endmodule

bind acc_alu_core acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_unary  (is_unary),
    .bin_op    (bin_op),
    .un_op     (un_op),
    .acc_in    (acc_in),
    .opnd_in   (opnd_in),
    .carry_in  (carry_in),
    .hcarry_in (hcarry_in),
    .res_out   (res_out),
    .carry_out (carry_out),
    .hcarry_out(hcarry_out),
    .flag_we   (flag_we),
    .skip_req  (skip_req)
);

// File: tb/sim_acc_alu_core.sv
`timescale 1ns/1ps
// Bench: vector table walked by one loop, then directed reset checks.
module sim_acc_alu_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_unary = 1'b0;
    logic [2:0] bin_op = 3'd0;
    logic [3:0] un_op = 4'd0;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd_in = 8'h00;
    logic       carry_in = 1'b0;
    logic       hcarry_in = 1'b0;
    logic [7:0] res_out;
    logic       carry_out, hcarry_out, flag_we, skip_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acc_alu_core #(.DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .is_unary(is_unary), .bin_op(bin_op),
        .un_op(un_op), .acc_in(acc_in), .opnd_in(opnd_in),
        .carry_in(carry_in), .hcarry_in(hcarry_in), .res_out(res_out),
        .carry_out(carry_out), .hcarry_out(hcarry_out), .flag_we(flag_we),
        .skip_req(skip_req)
    );

    // Vector: {un, bop, uop, A, B, c, hc, exp_res, exp_c, exp_hc, exp_we, exp_skip, req}
    localparam int NV = 38;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0,3'd0,4'd0,8'h3A,8'h59,1'b1,1'b0,8'h94,1'b0,1'b1,1'b1,1'b0,4'd2},  // R2
        {1'b0,3'd0,4'd0,8'hFF,8'h01,1'b0,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,4'd2},  // R2
        {1'b0,3'd1,4'd0,8'h50,8'h20,1'b1,1'b0,8'h30,1'b1,1'b1,1'b1,1'b0,4'd3},  // R3
        {1'b0,3'd1,4'd0,8'h20,8'h50,1'b1,1'b0,8'hD0,1'b0,1'b1,1'b1,1'b0,4'd3},  // R3
        {1'b0,3'd1,4'd0,8'h05,8'h03,1'b0,1'b0,8'h01,1'b1,1'b1,1'b1,1'b0,4'd3},  // R3
        {1'b0,3'd4,4'd0,8'hF0,8'h20,1'b1,1'b0,8'h10,1'b1,1'b0,1'b0,1'b0,4'd4},  // R4
        {1'b0,3'd4,4'd0,8'h80,8'h80,1'b0,1'b1,8'h00,1'b0,1'b1,1'b0,1'b0,4'd4},  // R4
        {1'b0,3'd5,4'd0,8'hCC,8'hAA,1'b1,1'b1,8'h88,1'b1,1'b1,1'b0,1'b0,4'd5},  // R5
        {1'b0,3'd6,4'd0,8'hCC,8'hAA,1'b0,1'b0,8'h66,1'b0,1'b0,1'b0,1'b0,4'd5},  // R5
        {1'b0,3'd7,4'd0,8'hCC,8'hAA,1'b1,1'b0,8'hEE,1'b1,1'b0,1'b0,1'b0,4'd5},  // R5
        {1'b0,3'd2,4'd0,8'h42,8'h42,1'b0,1'b1,8'h42,1'b0,1'b1,1'b0,1'b0,4'd6},  // R6
        {1'b0,3'd2,4'd0,8'h42,8'h43,1'b1,1'b0,8'h42,1'b1,1'b0,1'b0,1'b1,4'd6},  // R6
        {1'b0,3'd3,4'd0,8'h43,8'h42,1'b0,1'b0,8'h43,1'b0,1'b0,1'b0,1'b0,4'd7},  // R7
        {1'b0,3'd3,4'd0,8'h42,8'h42,1'b0,1'b0,8'h42,1'b0,1'b0,1'b0,1'b1,4'd7},  // R7
        {1'b0,3'd3,4'd0,8'h01,8'hFF,1'b1,1'b1,8'h01,1'b1,1'b1,1'b0,1'b1,4'd7},  // R7
        {1'b0,3'd3,4'd0,8'hFF,8'h01,1'b0,1'b0,8'hFF,1'b0,1'b0,1'b0,1'b0,4'd7},  // R7
        {1'b1,3'd0,4'd2,8'hFF,8'h00,1'b0,1'b1,8'h00,1'b0,1'b1,1'b0,1'b0,4'd8},  // R8
        {1'b1,3'd0,4'd3,8'h00,8'h00,1'b1,1'b0,8'hFF,1'b1,1'b0,1'b0,1'b0,4'd8},  // R8
        {1'b1,3'd0,4'd1,8'h5A,8'h00,1'b1,1'b1,8'h00,1'b1,1'b1,1'b0,1'b0,4'd8},  // R8
        {1'b1,3'd0,4'd4,8'hA5,8'h00,1'b0,1'b0,8'h5A,1'b0,1'b0,1'b0,1'b0,4'd9},  // R9
        {1'b1,3'd0,4'd6,8'h81,8'h00,1'b0,1'b1,8'h02,1'b1,1'b1,1'b1,1'b0,4'd10}, // R10
        {1'b1,3'd0,4'd7,8'h81,8'h00,1'b0,1'b0,8'h40,1'b1,1'b0,1'b1,1'b0,4'd10}, // R10
        {1'b1,3'd0,4'd7,8'h02,8'h00,1'b1,1'b1,8'h81,1'b0,1'b1,1'b1,1'b0,4'd10}, // R10
        {1'b1,3'd0,4'd5,8'hA2,8'h00,1'b0,1'b1,8'h42,1'b0,1'b1,1'b0,1'b0,4'd11}, // R11
        {1'b1,3'd0,4'd5,8'h7B,8'h00,1'b1,1'b0,8'h75,1'b1,1'b0,1'b0,1'b0,4'd11}, // R11
        {1'b1,3'd0,4'd5,8'h00,8'h00,1'b0,1'b0,8'h9A,1'b0,1'b0,1'b0,1'b0,4'd11}, // R11
        {1'b1,3'd0,4'd8,8'h33,8'h00,1'b0,1'b0,8'h33,1'b1,1'b0,1'b1,1'b0,4'd12}, // R12
        {1'b1,3'd0,4'd9,8'h33,8'h00,1'b1,1'b1,8'h33,1'b0,1'b1,1'b1,1'b0,4'd12}, // R12
        {1'b1,3'd0,4'd10,8'h11,8'h00,1'b0,1'b0,8'h11,1'b0,1'b0,1'b0,1'b1,4'd12},// R12
        {1'b1,3'd0,4'd10,8'h11,8'h00,1'b1,1'b0,8'h11,1'b1,1'b0,1'b0,1'b0,4'd12},// R12
        {1'b1,3'd0,4'd11,8'h11,8'h00,1'b1,1'b0,8'h11,1'b1,1'b0,1'b0,1'b1,4'd12},// R12
        {1'b1,3'd0,4'd11,8'h11,8'h00,1'b0,1'b0,8'h11,1'b0,1'b0,1'b0,1'b0,4'd12},// R12
        {1'b1,3'd0,4'd12,8'hF0,8'h0F,1'b0,1'b0,8'hF0,1'b0,1'b0,1'b0,1'b1,4'd13},// R13
        {1'b1,3'd0,4'd12,8'hF0,8'h10,1'b0,1'b0,8'hF0,1'b0,1'b0,1'b0,1'b0,4'd13},// R13
        {1'b1,3'd0,4'd0,8'h3C,8'h00,1'b1,1'b0,8'h3C,1'b1,1'b0,1'b0,1'b0,4'd14}, // R14
        {1'b1,3'd0,4'd13,8'hC3,8'h00,1'b0,1'b1,8'hC3,1'b0,1'b1,1'b0,1'b0,4'd14},// R14
        {1'b1,3'd0,4'd15,8'h99,8'hFF,1'b1,1'b1,8'h99,1'b1,1'b1,1'b0,1'b0,4'd14},// R14
        {1'b0,3'd4,4'd0,8'h01,8'h01,1'b1,1'b1,8'h02,1'b1,1'b1,1'b0,1'b0,4'd4}   // R4
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual={res,c,hc,we,skip}=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic apply(input logic [41:0] v);
        is_unary  = v[41];
        bin_op    = v[40:38];
        un_op     = v[37:34];
        acc_in    = v[33:26];
        opnd_in   = v[25:18];
        carry_in  = v[17];
        hcarry_in = v[16];
    endtask

    function automatic logic [11:0] outs();
        return {res_out, carry_out, hcarry_out, flag_we, skip_req};
    endfunction

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R0 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs are clear while reset is held
        repeat (3) @(negedge clk);
        check("R1", outs(), 12'h000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VEC[i][3:0], i), outs(), VEC[i][15:4]);
        end

        // R1: reset in mid-run clears a nonzero result on the next edge
        apply(VEC[0]);
        @(negedge clk);
        check("R1 pre", outs(), 12'h946);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run", outs(), 12'h000);
        rst_n = 1'b1;
        // R2: first operation after reset release is computed normally
        apply(VEC[1]);
        @(negedge clk);
        check("R2 after reset", outs(), VEC[1][15:4]);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule